// File: doc/BRIEF.md
# Dual Countdown Timer with Shared Interrupt

This peripheral holds two independent down-counters behind a small 32-bit register bus. Software loads a start value into a timer, then writes that timer's control register. The write copies the start value into the live counter and starts it. Each control word picks the rate at which its counter steps, from four tick-enable inputs or none at all. It also picks whether the counter reloads after each expiry or halts at zero.

Every expiry sets a sticky pending flag for that timer. Software masks the flags, reads back their masked view, and clears them by writing ones to an acknowledge offset. A single level-sensitive interrupt is high while any flag is both pending and unmasked. Reads are combinational. Writes take effect at the next clock edge.

Top module: `dual_countdown_timer`

## Requirements
- R1: Byte offsets 0x00/0x10 hold the start value of timer 0/1, read back in full. Offsets 0x08/0x18 hold the control word: bits [2:0] are the rate select and bit 3 is one-shot. The control word reads back in bits [3:0], with the upper bits zero.
- R2: A control write copies the timer's start value into its counter and starts it. Offsets 0x04/0x14 return the live count of timer 0/1.
- R3: With rate select 4, 5, 6 or 7, a running counter decrements by one in each cycle that tick_en[select-4] is high. The other tick bits have no effect on it.
- R4: With rate select 0 to 3, the counter never changes on ticks.
- R5: In reload mode (bit 3 = 0), a tick that finds the count at 1 or 0 is an expiry. The counter reloads from the start value and the pending flag is set.
- R6: In one-shot mode (bit 3 = 1), an expiry leaves the count at 0 and halts the timer. Later ticks do not change the count.
- R7: Pending bit 0 belongs to timer 0 and bit 1 to timer 1. A pending bit stays set until software writes a 1 to its position at offset 0x4C. If an expiry and a clearing write fall in the same cycle, the bit stays set.
- R8: Offset 0x48 is a 2-bit mask that reads back. Offset 0x54 returns pending AND mask. irq is high exactly when that value is nonzero.
- R9: Reset halts both timers, clears all registers and counts, and holds irq low.
- R10: Reads of unmapped offsets and of 0x4C return zero. Writes to 0x04, 0x14 and 0x54 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_en | input | 4 | Tick enables for rate selects 4 to 7 |
| irq | output | 1 | Level interrupt, pending AND mask nonzero |

## Verification
A timer expiry and a software acknowledge of the same pending bit can land on one clock edge. The bench arranges this by counting timer 0 down to 1. It then writes 1 to the acknowledge offset in the same cycle that it raises the selected tick. The check passes only if the masked status and irq still show the bit afterwards, and only if a later plain acknowledge clears it. A control write that coincides with a tick is also resolved in favour of the reload.

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer #(
  parameter int CNT_W = 32,
  parameter int AW    = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [3:0]  tick_en,
  output logic        irq
);
  localparam logic [AW-1:0] A_MASK = AW'(7'h48);
  localparam logic [AW-1:0] A_ACK  = AW'(7'h4C);
  localparam logic [AW-1:0] A_STAT = AW'(7'h54);

  logic [CNT_W-1:0] div_q [2];
  logic [CNT_W-1:0] cnt_q [2];
  logic [3:0]       ctrl_q [2];
  logic [1:0] run_q, pend_q, mask_q;
  logic [1:0] wr_div, wr_ctrl, adv, hit;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      wr_div[i]  = bus_we && (bus_addr == AW'(16 * i));
      wr_ctrl[i] = bus_we && (bus_addr == AW'(16 * i + 8));
      adv[i]     = run_q[i] && ctrl_q[i][2] && tick_en[ctrl_q[i][1:0]];
      hit[i]     = adv[i] && !wr_ctrl[i] && (cnt_q[i] <= CNT_W'(1));
    end
  end

  wire       ack_wr  = bus_we && (bus_addr == A_ACK);
  wire [1:0] ack_bits = ack_wr ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        div_q[i]  <= '0;
        cnt_q[i]  <= '0;
        ctrl_q[i] <= '0;
      end
      run_q  <= '0;
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (wr_div[i]) div_q[i] <= bus_wdata[CNT_W-1:0];
        if (wr_ctrl[i]) begin
          ctrl_q[i] <= bus_wdata[3:0];
          cnt_q[i]  <= div_q[i];
          run_q[i]  <= 1'b1;
        end else if (adv[i]) begin
          if (cnt_q[i] <= CNT_W'(1)) begin
            cnt_q[i] <= ctrl_q[i][3] ? '0 : div_q[i];
            if (ctrl_q[i][3]) run_q[i] <= 1'b0;
          end else begin
            cnt_q[i] <= cnt_q[i] - CNT_W'(1);
          end
        end
      end
      if (bus_we && bus_addr == A_MASK) mask_q <= bus_wdata[1:0];
      pend_q <= (pend_q & ~ack_bits) | hit;
    end
  end

  wire [1:0] masked = pend_q & mask_q;
  assign irq = |masked;

  always_comb begin
    case (bus_addr)
      AW'(7'h00): bus_rdata = 32'(div_q[0]);
      AW'(7'h04): bus_rdata = 32'(cnt_q[0]);
      AW'(7'h08): bus_rdata = {28'd0, ctrl_q[0]};
      AW'(7'h10): bus_rdata = 32'(div_q[1]);
      AW'(7'h14): bus_rdata = 32'(cnt_q[1]);
      AW'(7'h18): bus_rdata = {28'd0, ctrl_q[1]};
      A_MASK:     bus_rdata = {30'd0, mask_q};
      A_STAT:     bus_rdata = {30'd0, masked};
      default:    bus_rdata = 32'd0;
    endcase
  end
endmodule

module dual_countdown_timer_sva #(
  parameter int CNT_W = 32,
  parameter int AW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [31:0]      bus_wdata,
  input logic             irq,
  input logic [1:0]       pend,
  input logic [1:0]       mask,
  input logic [1:0]       hit,
  input logic [1:0]       run,
  input logic [3:0]       ctrl0,
  input logic [3:0]       ctrl1,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [CNT_W-1:0] div0
);
  wire wr_c0  = bus_we && bus_addr == AW'(7'h08);
  wire wr_d0  = bus_we && bus_addr == AW'(7'h00);
  wire wr_ack = bus_we && bus_addr == AW'(7'h4C);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl0[2] && !wr_c0) |=> $stable(cnt0));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && !ctrl0[3] && !wr_d0) |=> (cnt0 == div0));

  p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && ctrl1[3]) |=> (!run[1] && cnt1 == '0));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> pend[0]);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && bus_wdata[0] && !hit[0]) |=> !pend[0]);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[1] && !(wr_ack && bus_wdata[1])) |=> pend[1]);

  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != 2'b00 && mask != 2'b00));

  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r9: assert (!irq && run == 2'b00);
endmodule

bind dual_countdown_timer dual_countdown_timer_sva #(.CNT_W(CNT_W), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq(irq), .pend(pend_q), .mask(mask_q),
  .hit(hit), .run(run_q), .ctrl0(ctrl_q[0]), .ctrl1(ctrl_q[1]),
  .cnt0(cnt_q[0]), .cnt1(cnt_q[1]), .div0(div_q[0])
);

// File: tb/sim_dual_countdown_timer.sv
module sim_dual_countdown_timer;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_en = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  dual_countdown_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // op: 0 write, 1 read-and-compare, 2 idle cycle with ticks
  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  a;
    logic [31:0] d;
    logic [3:0]  t;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 7'h00, 32'd5,  4'h0, 8'd1},
    '{2'd1, 7'h00, 32'd5,  4'h0, 8'd1},   // R1
    '{2'd0, 7'h08, 32'h4,  4'h0, 8'd2},
    '{2'd1, 7'h04, 32'd5,  4'h0, 8'd2},   // R2
    '{2'd1, 7'h08, 32'h4,  4'h0, 8'd1},
    '{2'd2, 7'h00, 32'd0,  4'h1, 8'd3},
    '{2'd2, 7'h00, 32'd0,  4'h2, 8'd3},
    '{2'd1, 7'h04, 32'd4,  4'h0, 8'd3},   // R3
    '{2'd2, 7'h00, 32'd0,  4'h1, 8'd3},
    '{2'd2, 7'h00, 32'd0,  4'h1, 8'd3},
    '{2'd2, 7'h00, 32'd0,  4'h1, 8'd3},
    '{2'd1, 7'h54, 32'd0,  4'h0, 8'd8},   // R8
    '{2'd2, 7'h00, 32'd0,  4'h1, 8'd5},
    '{2'd1, 7'h04, 32'd5,  4'h0, 8'd5},   // R5
    '{2'd0, 7'h48, 32'd1,  4'h0, 8'd8},
    '{2'd1, 7'h54, 32'd1,  4'h0, 8'd5},
    '{2'd1, 7'h48, 32'd1,  4'h0, 8'd8},
    '{2'd0, 7'h4C, 32'd1,  4'h0, 8'd7},
    '{2'd1, 7'h54, 32'd0,  4'h0, 8'd7},   // R7
    '{2'd0, 7'h10, 32'd2,  4'h0, 8'd1},
    '{2'd0, 7'h18, 32'hF,  4'h0, 8'd6},
    '{2'd2, 7'h00, 32'd0,  4'h8, 8'd6},
    '{2'd2, 7'h00, 32'd0,  4'h8, 8'd6},
    '{2'd1, 7'h14, 32'd0,  4'h0, 8'd6},   // R6
    '{2'd2, 7'h00, 32'd0,  4'h8, 8'd6},
    '{2'd1, 7'h14, 32'd0,  4'h0, 8'd6},
    '{2'd0, 7'h48, 32'd3,  4'h0, 8'd8},
    '{2'd1, 7'h54, 32'd2,  4'h0, 8'd8},
    '{2'd0, 7'h14, 32'h77, 4'h0, 8'd10},
    '{2'd1, 7'h14, 32'd0,  4'h0, 8'd10},  // R10
    '{2'd1, 7'h20, 32'd0,  4'h0, 8'd10},
    '{2'd1, 7'h4C, 32'd0,  4'h0, 8'd10},
    '{2'd0, 7'h18, 32'h3,  4'h0, 8'd4},
    '{2'd2, 7'h00, 32'd0,  4'hF, 8'd4},
    '{2'd1, 7'h14, 32'd2,  4'h0, 8'd4},   // R4
    '{2'd0, 7'h4C, 32'd2,  4'h0, 8'd7},
    '{2'd1, 7'h54, 32'd0,  4'h0, 8'd7},
    '{2'd0, 7'h18, 32'h5,  4'h0, 8'd3},
    '{2'd2, 7'h00, 32'd0,  4'h2, 8'd3},
    '{2'd1, 7'h14, 32'd1,  4'h0, 8'd3}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [6:0] a, input logic [31:0] d, input logic [3:0] t);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick_en = t;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    bus_addr = 7'h00; #1; check("R9 div0", bus_rdata, 0);
    bus_addr = 7'h08; #1; check("R9 ctrl0", bus_rdata, 0);
    bus_addr = 7'h54; #1; check("R9 status", bus_rdata, 0);
    check("R9 irq", {31'd0, irq}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].op == 2'd0, VEC[i].a, VEC[i].d, VEC[i].t);
      if (VEC[i].op == 2'd1)
        check($sformatf("R%0d vec%0d", VEC[i].req, i), bus_rdata, VEC[i].d);
    end

    // R7: expiry and acknowledge in the same cycle, set wins
    cyc(1, 7'h00, 32'd2, 4'h0);
    cyc(1, 7'h08, 32'h4, 4'h0);
    cyc(0, 7'h00, 32'd0, 4'h1);
    cyc(1, 7'h4C, 32'd1, 4'h1);
    cyc(0, 7'h54, 32'd0, 4'h0);
    check("R7 set beats ack", bus_rdata, 32'd1);
    check("R8 irq high", {31'd0, irq}, 1);
    cyc(0, 7'h04, 32'd0, 4'h0);
    check("R5 reload after expiry", bus_rdata, 32'd2);
    cyc(1, 7'h4C, 32'd1, 4'h0);
    cyc(0, 7'h54, 32'd0, 4'h0);
    check("R7 ack clears", bus_rdata, 32'd0);
    check("R8 irq low", {31'd0, irq}, 0);

    // R2: control write coincident with a tick reloads
    cyc(1, 7'h08, 32'h4, 4'h1);
    cyc(0, 7'h04, 32'd0, 4'h0);
    check("R2 reload wins over tick", bus_rdata, 32'd2);

    // R9: reset while running
    cyc(1, 7'h00, 32'd1, 4'h0);
    cyc(1, 7'h08, 32'h4, 4'h0);
    cyc(0, 7'h04, 32'd0, 4'h1);
    cyc(0, 7'h54, 32'd0, 4'h0);
    check("R9 pre-reset irq", {31'd0, irq}, 1);
    rst_n = 1'b0; #1;
    check("R9 irq in reset", {31'd0, irq}, 0);
    bus_addr = 7'h04; #1;
    check("R9 count in reset", bus_rdata, 0);
    cyc(0, 7'h04, 32'd0, 4'hF);
    rst_n = 1'b1;
    cyc(0, 7'h04, 32'd0, 4'hF);
    cyc(0, 7'h04, 32'd0, 4'h0);
    check("R9 halted after reset", bus_rdata, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule